// File: doc/BRIEF.md
# Crystal Startup Supervisor

At boot, this block decides whether the external crystal may clock the system. If it cannot, the system stays on the internal RC oscillator. The block runs on the fast internal reference clock.

Once power-on reset is released, the block enables the crystal driver. It then waits a settle interval, counted in pulses of a slow tick enable that comes from the divided internal RC clock. After that wait it looks for crystal activity: it counts rising edges of the crystal signal after they pass through a synchronizer.

A second timer runs on the reference clock. Its deadline is one and a half times the settle interval. If the crystal is not confirmed before that deadline, the block falls back to safe mode and reports the internal clock as the selection.

The settle length comes from an 8-bit tuning fuse byte. A blank (zero) fuse selects a built-in default. The outcome is reported as status only; the clock multiplexer itself is outside the block.

Top module: `xtal_start_supervisor`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `xtal_en`, `xtal_ready`, `clk_sel_xtal` and `safe_mode` are all 0 after that edge.
- R2: On the first edge with `rst_n` high, the block samples `fuse_tune`. A value of 0 gives settle count N = 0x57; any nonzero value is used as N directly. From that edge on, `xtal_en` is 1.
- R3: The settle wait ends on the (N+1)-th `slow_tick` pulse seen after the wait starts, so N = 0xFF means 256 pulses. `slow_tick` pulses outside the wait do nothing.
- R4: Crystal rising edges that arrive during the settle wait are not counted toward confirmation.
- R5: After the settle wait, the crystal is confirmed on the EDGES_MIN-th rising edge. Edges are counted at the output of a two-flop synchronizer, so a raw rise first driven for edge c is counted at edge c+2. On confirmation, `xtal_ready` and `clk_sel_xtal` become 1; `clk_sel_xtal` = 1 means the crystal is selected.
- R6: Let W = (N+1)·REF_PER_TICK and L = W + W/2, with W/2 rounded down. If the crystal is not yet confirmed, `safe_mode` rises L+1 edges after the release edge. At the same time `xtal_en` drops to 0 and `clk_sel_xtal` stays 0.
- R7: The deadline counts reference cycles only, so it expires even when no `slow_tick` pulse ever arrives.
- R8: The ready and safe outcomes stay fixed until the next reset; later crystal activity or silence does not change them.
- R9: `xtal_ready` and `safe_mode` are never 1 together, and `clk_sel_xtal` is 1 only while `xtal_ready` is 1.
- R10: If confirmation and deadline expiry fall on the same edge, the deadline wins and the block enters safe mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast internal reference clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| slow_tick | input | 1 | One-cycle enable per slow RC clock period |
| xtal_in | input | 1 | Sampled crystal clock signal (asynchronous) |
| fuse_tune | input | TUNE_W | Tuning fuse byte; 0 selects the default settle count |
| xtal_en | output | 1 | Crystal driver enable |
| xtal_ready | output | 1 | Crystal confirmed and usable |
| clk_sel_xtal | output | 1 | Clock-select status: 1 crystal, 0 internal RC |
| safe_mode | output | 1 | Deadline missed; system stays on the RC clock |

## Verification
The block is tried with the following patterns, and each one separates a different fault:

- **Running crystal, small fuse value.** Checks the exact edge on which `xtal_ready` rises.
- **Blank fuse.** Separates the default settle count from a literal zero.
- **All-ones fuse.** Exercises the longest wait.
- **Dead crystal.** Shows the deadline arriving at exactly L+1.
- **Missing tick.** Shows that the deadline does not depend on the slow clock.
- **Crystal that runs only during the settle wait.** Shows that early edges are ignored.
- **Two late-starting crystals, one cycle apart.** One is confirmed on the last legal edge; the other coincides with the deadline, and the deadline must win.
- **Crystal changes after the outcome, and a reset in mid-run.** Check that both outcomes stick and that reset clears them.

A behavioural model compares all four outputs on every clock.

// File: rtl/xsup_pkg.sv
// Shared types for the crystal startup supervisor.
package xsup_pkg;
    typedef enum logic [2:0] {
        XS_RESET  = 3'd0,
        XS_SETTLE = 3'd1,
        XS_CHECK  = 3'd2,
        XS_READY  = 3'd3,
        XS_SAFE   = 3'd4
    } xs_state_t;
endpackage

// File: rtl/xsup_edge_sync.sv
// Synchronizes the asynchronous crystal signal into the reference domain
// and flags each rising edge for one cycle.
// Assumes: STAGES >= 2; one extra flop behind the chain detects the edge.
module xsup_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain_q;

    // Shift the raw level through the synchronizer and the edge flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], din};
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/xsup_settle_timer.sv
// Counts slow tick pulses for the settle wait. The settle count N is taken
// from the fuse byte on load (zero selects DEFAULT_TUNE).
// done pulses on the (N+1)-th tick while run is high.
// Assumes: load and run are never high together.
module xsup_settle_timer #(
    parameter int TUNE_W       = 8,
    parameter int DEFAULT_TUNE = 'h57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic              tick,
    input  logic [TUNE_W-1:0] fuse,
    output logic [TUNE_W-1:0] settle_n,
    output logic              done
);
    localparam logic [TUNE_W-1:0] DEF_N = TUNE_W'(DEFAULT_TUNE);

    logic [TUNE_W-1:0] n_q;
    logic [TUNE_W-1:0] cnt_q;

    // Latch the settle count at load; advance the tick count during the wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q   <= '0;
            cnt_q <= '0;
        end else if (load) begin
            n_q   <= (fuse == '0) ? DEF_N : fuse;
            cnt_q <= '0;
        end else if (run && tick && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done     = run && tick && (cnt_q == n_q);
    assign settle_n = n_q;

    assert_tick_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= n_q))
        else $error("tick count passed settle count");

    assert_tick_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q))
        else $error("tick count moved outside settle wait");
endmodule

// File: rtl/xsup_deadline.sv
// Deadline timer on the reference clock. The limit is 1.5 times the settle
// wait expressed in reference cycles: W = (N+1)*REF_PER_TICK, L = W + (W>>1).
// hit is high while run is high and the count equals L.
// Assumes: the limit stays fixed while run is high.
module xsup_deadline #(
    parameter int TUNE_W       = 8,
    parameter int REF_PER_TICK = 750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [TUNE_W-1:0] settle_n,
    output logic              hit
);
    localparam int DL_W = $clog2(((2 ** TUNE_W) * REF_PER_TICK * 3) / 2 + 1);

    logic [TUNE_W:0]  n_plus;
    logic [DL_W-1:0]  wait_ref;
    logic [DL_W-1:0]  limit;
    logic [DL_W-1:0]  cnt_q;

    // Form the deadline from the settle count with a shift and add.
    always_comb begin
        n_plus   = {1'b0, settle_n} + {{TUNE_W{1'b0}}, 1'b1};
        wait_ref = DL_W'(n_plus) * DL_W'(REF_PER_TICK);
        limit    = wait_ref + (wait_ref >> 1);
    end

    // Count reference cycles spent waiting, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= '0;
        else if (run && !hit)   cnt_q <= cnt_q + 1'b1;
    end

    assign hit = run && (cnt_q == limit);

    assert_dl_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit))
        else $error("deadline count passed limit");

    assert_dl_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !hit) |=> (cnt_q == $past(cnt_q) + 1'b1))
        else $error("deadline count stalled");
endmodule

// File: rtl/xsup_edge_count.sv
// Counts synchronized crystal rising edges while run is high. confirmed
// pulses on the EDGES_MIN-th edge.
// Assumes: EDGES_MIN >= 1; clear and run are never high together.
module xsup_edge_count #(
    parameter int EDGES_MIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic rise,
    output logic confirmed
);
    localparam int            EC_W = $clog2(EDGES_MIN + 1);
    localparam logic [EC_W-1:0] LAST = EC_W'(EDGES_MIN - 1);

    logic [EC_W-1:0] cnt_q;

    // Accumulate edges only during the check phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (clear)                      cnt_q <= '0;
        else if (run && rise && !confirmed)  cnt_q <= cnt_q + 1'b1;
    end

    assign confirmed = run && rise && (cnt_q == LAST);

    assert_edge_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < EC_W'(EDGES_MIN))
        else $error("edge count reached limit without confirming");

    assert_edge_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(cnt_q))
        else $error("edge counted outside check phase");
endmodule

// File: rtl/xtal_start_supervisor.sv
// Boot-time crystal supervisor. After reset it enables the crystal, waits
// N+1 slow ticks, then needs EDGES_MIN synchronized crystal edges before a
// reference-clock deadline of 1.5 times the wait. It ends in READY (crystal
// selected) or SAFE (internal RC kept); both hold until the next reset.
// Assumes: slow_tick is a one-cycle pulse in the clk_ref domain.
module xtal_start_supervisor
    import xsup_pkg::*;
#(
    parameter int TUNE_W       = 8,
    parameter int DEFAULT_TUNE = 'h57,
    parameter int REF_PER_TICK = 750,
    parameter int EDGES_MIN    = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              xtal_in,
    input  logic [TUNE_W-1:0] fuse_tune,
    output logic              xtal_en,
    output logic              xtal_ready,
    output logic              clk_sel_xtal,
    output logic              safe_mode
);
    xs_state_t         state_q;
    xs_state_t         state_d;
    logic              start;
    logic              in_settle;
    logic              in_check;
    logic              in_wait;
    logic              rise;
    logic              settle_done;
    logic              dl_hit;
    logic              confirmed;
    logic [TUNE_W-1:0] settle_n;

    assign start     = (state_q == XS_RESET);
    assign in_settle = (state_q == XS_SETTLE);
    assign in_check  = (state_q == XS_CHECK);
    assign in_wait   = in_settle || in_check;

    xsup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_ref), .rst_n(rst_n), .din(xtal_in), .rise(rise)
    );

    xsup_settle_timer #(.TUNE_W(TUNE_W), .DEFAULT_TUNE(DEFAULT_TUNE)) u_settle (
        .clk(clk_ref), .rst_n(rst_n), .load(start), .run(in_settle),
        .tick(slow_tick), .fuse(fuse_tune), .settle_n(settle_n), .done(settle_done)
    );

    xsup_deadline #(.TUNE_W(TUNE_W), .REF_PER_TICK(REF_PER_TICK)) u_deadline (
        .clk(clk_ref), .rst_n(rst_n), .load(start), .run(in_wait),
        .settle_n(settle_n), .hit(dl_hit)
    );

    xsup_edge_count #(.EDGES_MIN(EDGES_MIN)) u_edges (
        .clk(clk_ref), .rst_n(rst_n), .clear(start), .run(in_check),
        .rise(rise), .confirmed(confirmed)
    );

    // Next-state choice; the deadline takes priority over progress.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_RESET:  state_d = XS_SETTLE;
            XS_SETTLE: if (dl_hit) state_d = XS_SAFE;
                       else if (settle_done) state_d = XS_CHECK;
            XS_CHECK:  if (dl_hit) state_d = XS_SAFE;
                       else if (confirmed) state_d = XS_READY;
            XS_READY:  state_d = XS_READY;
            XS_SAFE:   state_d = XS_SAFE;
            default:   state_d = XS_RESET;
        endcase
    end

    // State register with synchronous power-on reset.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) state_q <= XS_RESET;
        else        state_q <= state_d;
    end

    // Status decode.
    always_comb begin
        xtal_en      = (state_q == XS_SETTLE) || (state_q == XS_CHECK) ||
                       (state_q == XS_READY);
        xtal_ready   = (state_q == XS_READY);
        clk_sel_xtal = (state_q == XS_READY);
        safe_mode    = (state_q == XS_SAFE);
    end

    assert_exclusive_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(xtal_ready && safe_mode))
        else $error("ready and safe together");

    assert_sel_ready_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        clk_sel_xtal |-> xtal_ready)
        else $error("crystal selected without ready");

    assert_ready_sticky_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        xtal_ready |=> xtal_ready)
        else $error("ready dropped");

    assert_safe_sticky_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        safe_mode |=> safe_mode)
        else $error("safe mode dropped");

    assert_deadline_safe_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        dl_hit |=> (safe_mode && !xtal_en))
        else $error("deadline missed without fallback");

    assert_ready_cause_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (in_check && confirmed && !dl_hit) |=> xtal_ready)
        else $error("confirmation did not set ready");
endmodule

// File: tb/xtal_start_supervisor_test.sv
// Self-checking bench: a behavioural model is stepped on every clock and
// compared with all outputs; scenario-end checks use closed-form timings.
module xtal_start_supervisor_test;
    localparam int RPT   = 8;
    localparam int EDGES = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       xtal_in = 1'b0;
    logic [7:0] fuse_tune = 8'd0;
    logic       xtal_en, xtal_ready, clk_sel_xtal, safe_mode;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // stimulus mode
    int fuse_v, x_half, x_start, x_stop, tick_on;
    int cyc_rel;
    int first_ready, first_safe;
    bit in_rst;

    // model state
    int m_state, m_n, m_ticks, m_dl, m_edges;
    int m_c0, m_c1, m_c2;

    always #2.5 clk = ~clk;

    xtal_start_supervisor #(.REF_PER_TICK(RPT), .EDGES_MIN(EDGES)) uut (
        .clk_ref(clk), .rst_n(rst_n), .slow_tick(slow_tick), .xtal_in(xtal_in),
        .fuse_tune(fuse_tune), .xtal_en(xtal_en), .xtal_ready(xtal_ready),
        .clk_sel_xtal(clk_sel_xtal), .safe_mode(safe_mode)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc_rel, act, expv);
        end
    endtask

    function automatic int m_limit();
        int w;
        w = (m_n + 1) * RPT;
        return w + w / 2;
    endfunction

    task automatic model_step(input bit r, input bit t, input bit x, input int f);
        bit rise_o;
        rise_o = (m_c1 == 1) && (m_c2 == 0);
        if (!r) begin
            m_state = 0; m_n = 0; m_ticks = 0; m_dl = 0; m_edges = 0;
            m_c0 = 0; m_c1 = 0; m_c2 = 0;
        end else begin
            if (m_state == 0) begin
                m_state = 1; m_n = (f == 0) ? 'h57 : f;
                m_ticks = 0; m_dl = 0; m_edges = 0;
            end else if (m_state == 1 || m_state == 2) begin
                if (m_dl == m_limit()) m_state = 4;
                else begin
                    m_dl++;
                    if (m_state == 1) begin
                        if (t) begin
                            if (m_ticks == m_n) m_state = 2;
                            else m_ticks++;
                        end
                    end else if (rise_o) begin
                        if (m_edges == EDGES - 1) m_state = 3;
                        else m_edges++;
                    end
                end
            end
            m_c2 = m_c1; m_c1 = m_c0; m_c0 = int'(x);
        end
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            bit t, x;
            int c;
            @(negedge clk);
            c = cyc_rel;
            t = (tick_on != 0) && !in_rst && (c % RPT == RPT - 1);
            x = (x_half > 0) && !in_rst && (c >= x_start) && (c < x_stop) &&
                (((c - x_start) / x_half) % 2 == 1);
            slow_tick = t;
            xtal_in   = x;
            fuse_tune = 8'(fuse_v);
            rst_n     = !in_rst;
            @(posedge clk);
            #1;
            model_step(!in_rst, t, x, fuse_v);
            check(xtal_en == (m_state >= 1 && m_state <= 3), in_rst ? "R1 xtal_en" : "R2 xtal_en",
                  int'(xtal_en), int'(m_state >= 1 && m_state <= 3));
            check(xtal_ready == (m_state == 3), in_rst ? "R1 ready" : "R5 ready",
                  int'(xtal_ready), int'(m_state == 3));
            check(safe_mode == (m_state == 4), in_rst ? "R1 safe" : "R6 safe",
                  int'(safe_mode), int'(m_state == 4));
            check(clk_sel_xtal == (m_state == 3), in_rst ? "R1 clk_sel" : "R9 clk_sel",
                  int'(clk_sel_xtal), int'(m_state == 3));
            if (!in_rst && xtal_ready && first_ready < 0) first_ready = c;
            if (!in_rst && safe_mode && first_safe < 0) first_safe = c;
            cyc_rel++;
        end
    endtask

    task automatic boot(input int f, input int half, input int xs, input int xe, input int tk);
        fuse_v = f; x_half = half; x_start = xs; x_stop = xe; tick_on = tk;
        in_rst = 1'b1;
        cyc_rel = 0;
        run_cycles(3);
        in_rst = 1'b0;
        cyc_rel = 0;
        first_ready = -1;
        first_safe = -1;
    endtask

    initial begin
        // Fuse 3, crystal running from the start: ready on edge 44.
        boot(3, 2, 0, 1 << 30, 1);
        run_cycles(80);
        check(first_ready == 44, "R5 ready edge", first_ready, 44);
        check(first_ready > 31, "R3 settle ends before ready", first_ready, 32);
        check(first_safe < 0, "R9 no safe with ready", first_safe, -1);

        // Ready is sticky after the crystal stops (R8).
        x_stop = cyc_rel;
        run_cycles(100);
        check(xtal_ready == 1'b1, "R8 ready sticky", int'(xtal_ready), 1);

        // Reset mid-run clears everything (R1).
        in_rst = 1'b1;
        run_cycles(2);
        check(xtal_ready == 1'b0 && xtal_en == 1'b0, "R1 reset clears", int'(xtal_ready), 0);

        // Dead crystal, fuse 3: safe on edge L+1 = 49.
        boot(3, 0, 0, 0, 1);
        run_cycles(80);
        check(first_safe == 49, "R6 deadline edge", first_safe, 49);
        check(xtal_en == 1'b0, "R6 crystal disabled in safe", int'(xtal_en), 0);

        // Safe is sticky when the crystal appears later (R8).
        x_half = 2; x_start = cyc_rel; x_stop = 1 << 30;
        run_cycles(100);
        check(safe_mode == 1'b1 && xtal_ready == 1'b0, "R8 safe sticky", int'(safe_mode), 1);

        // Blank fuse uses default 0x57: 88th tick lands on edge 703.
        boot(0, 2, 0, 1 << 30, 1);
        run_cycles(800);
        check(first_ready > 703 && first_ready < 740, "R2 default settle count", first_ready, 720);

        // Largest fuse value: 256 ticks, last on edge 2047.
        boot(255, 2, 0, 1 << 30, 1);
        run_cycles(2150);
        check(first_ready > 2047 && first_ready < 2080, "R3 full wait", first_ready, 2060);

        // No slow ticks: the deadline still fires (R7).
        boot(3, 2, 0, 1 << 30, 0);
        run_cycles(80);
        check(first_safe == 49, "R7 deadline without ticks", first_safe, 49);

        // Crystal active only during the settle wait: early edges ignored (R4).
        boot(3, 2, 0, 30, 1);
        run_cycles(80);
        check(first_safe == 49 && first_ready < 0, "R4 early edges ignored", first_safe, 49);

        // Late crystal confirmed on the last legal edge 48.
        boot(3, 2, 32, 1 << 30, 1);
        run_cycles(80);
        check(first_ready == 48, "R5 last legal edge", first_ready, 48);

        // Confirmation coincides with the deadline: safe wins (R10).
        boot(3, 2, 33, 1 << 30, 1);
        run_cycles(80);
        check(first_safe == 49 && first_ready < 0, "R10 deadline priority", first_safe, 49);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule